// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block drives one clock output pin from a 16 MHz reference clock. A 3-bit rate code selects the output frequency. Six codes divide the reference. One code passes the reference straight through. Code 0 stops the output and holds it low.

A defer-select bit decides when a newly written rate code becomes active:

- **Defer bit 0:** the new code is applied at the next safe point of the output waveform.
- **Defer bit 1:** the new code is parked in a shadow register. It is applied only when the chip wakes from its next sleep period. Wake-up is marked by a falling edge on the sleep input.

All rate switches happen at a low-phase boundary of the output. The output therefore never shows a shortened pulse. Every divided output has a 50% duty cycle.

The sleep input may be asynchronous. It passes through a synchronizer of parameterised depth before its falling edge is detected. A rate write is judged against the defer bit as it stands before that write. If both fields are written in the same cycle, the new defer value governs only later rate writes.

Top module: `clko_gen`

## Requirements
- R1: After reset the active rate code is 1 (divide by 16), the shadow code is 1 and the defer bit is 0. The output is low while reset is held.
- R2: With rate code 0 active, the output stays at logic low.
- R3: Rate codes 1, 2, 3, 4 and 5 give output periods of 16, 8, 4, 2 and 1 reference cycles. Code 5 passes the reference clock through.
- R4: Rate code 6 gives an output period of 64 reference cycles. Rate code 7 gives 256 reference cycles, which is 62.5 kHz.
- R5: A rate write made while the defer bit is 0 becomes active at the next low-phase boundary, with no sleep cycle needed.
- R6: A rate write made while the defer bit is 1 leaves the output rate unchanged until the sleep input falls. Entering sleep (a rising edge) has no effect. If several deferred writes arrive before wake-up, only the last one is applied.
- R7: Rate changes take effect only at a low-phase boundary. Every completed high phase lasts exactly one half-period of either the old or the new rate. No low phase is shorter than the shorter of the two half-periods.
- R8: Every output setting other than code 0 has high and low phases of equal length, each one half of its period.
- R9: A non-deferred write cancels any deferred code that is still waiting. A wake-up with no deferred code waiting leaves the active rate unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 16 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_we | input | 1 | Write strobe for the rate code |
| rate_wdata | input | 3 | Rate code to write |
| defer_we | input | 1 | Write strobe for the defer-select bit |
| defer_wdata | input | 1 | Defer-select value (1 = wait for wake-up) |
| sleep_in | input | 1 | High while asleep; its falling edge marks wake-up |
| clk_out | output | 1 | Divided clock output |

## Verification
The hardest situation to reach from the ports is a deferred code that must survive several conditions before it is applied:
- overwrites,
- an entry into sleep,
- a competing non-deferred write.

Each of these must happen while the output keeps running at the old rate. The bench sets the defer bit and writes several codes. It confirms by measuring phase lengths that the old period persists through a sleep entry. It then releases sleep and measures the last-written rate. The bench also sweeps every code in a non-monotonic order with immediate writes. During each switch, a phase monitor checks every completed high and low run against the old and new half-periods.

// File: rtl/clko_pkg.sv
package clko_pkg;

   localparam int unsigned RATE_W   = 3;
   localparam int unsigned MAX_LOG2 = 8;

   typedef logic [RATE_W-1:0] rate_t;

   localparam rate_t RATE_OFF  = rate_t'(0);
   localparam rate_t RATE_PASS = rate_t'(5);

   // log2 of the division ratio for each rate code (code 0 has no clock)
   function automatic int unsigned rate_log2(input rate_t r);
      int unsigned lg;
      case (r)
         3'd1:    lg = 4;
         3'd2:    lg = 3;
         3'd3:    lg = 2;
         3'd4:    lg = 1;
         3'd5:    lg = 0;
         3'd6:    lg = 6;
         3'd7:    lg = 8;
         default: lg = 0;
      endcase
      return lg;
   endfunction

   function automatic logic rate_is_off(input rate_t r);
      return (r == RATE_OFF);
   endfunction

   function automatic logic rate_is_pass(input rate_t r);
      return (r == RATE_PASS);
   endfunction

endpackage

// File: rtl/clko_sync.sv
module clko_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else if (STAGES == 1) chain <= d_in;
            else chain <= {chain[STAGES-2:0], d_in};
         end
         assign d_out = chain[STAGES-1];
      end
      if (STAGES > 4) begin : g_bad_depth
         $error("clko_sync: STAGES must be 0..4");
      end
   endgenerate

endmodule

// File: rtl/clko_ctrl.sv
module clko_ctrl
   import clko_pkg::*;
#(
   parameter rate_t       RESET_RATE  = rate_t'(1),
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  rate_we,
   input  rate_t rate_wdata,
   input  logic  defer_we,
   input  logic  defer_wdata,
   input  logic  sleep_in,
   input  logic  apply_ack,
   output logic  req_valid,
   output rate_t req_rate
);

   logic  sleep_s;
   logic  sleep_d;
   logic  wake;
   logic  defer_q;
   logic  waiting;
   rate_t shadow;

   clko_sync #(.STAGES(SYNC_STAGES)) u_sleep_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (sleep_in),
      .d_out (sleep_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sleep_d <= 1'b0;
      else        sleep_d <= sleep_s;
   end

   assign wake = sleep_d & ~sleep_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) defer_q <= 1'b0;
      else if (defer_we) defer_q <= defer_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow    <= RESET_RATE;
         waiting   <= 1'b0;
         req_valid <= 1'b0;
         req_rate  <= RESET_RATE;
      end else begin
         if (apply_ack) req_valid <= 1'b0;
         if (rate_we) begin
            shadow <= rate_wdata;
            if (!defer_q) begin
               req_rate  <= rate_wdata;
               req_valid <= 1'b1;
               waiting   <= 1'b0;
            end else begin
               waiting <= 1'b1;
            end
         end else if (wake && waiting) begin
            req_rate  <= shadow;
            req_valid <= 1'b1;
            waiting   <= 1'b0;
         end
      end
   end

   a_r5_immediate_request: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_we && !defer_q) |=> (req_valid && req_rate == $past(rate_wdata)));

   a_r6_deferred_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_we && defer_q && !req_valid) |=> !req_valid);

   a_r6_wake_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && waiting && !rate_we) |=> (req_valid && req_rate == $past(shadow)));

   a_r9_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && !waiting && !rate_we && !req_valid) |=> !req_valid);

endmodule

// File: rtl/clko_div.sv
module clko_div
   import clko_pkg::*;
#(
   parameter rate_t       RESET_RATE = rate_t'(1),
   parameter int unsigned CNT_W      = MAX_LOG2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  req_valid,
   input  rate_t req_rate,
   output logic  apply_ack,
   output logic  clk_out
);

   rate_t       active;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] half_m1;
   logic        q_div;
   logic        g_pass;
   logic        mode_off;
   logic        mode_pass;
   logic        at_boundary;
   int unsigned lg;

   if (CNT_W < MAX_LOG2) begin : g_bad_cnt
      $error("clko_div: CNT_W too small for the slowest rate");
   end

   always_comb begin
      lg        = rate_log2(active);
      mode_off  = rate_is_off(active);
      mode_pass = rate_is_pass(active);
      if (lg == 0) half_m1 = '0;
      else         half_m1 = CNT_W'((32'd1 << (lg - 1)) - 32'd1);
      at_boundary = mode_off || mode_pass || (!q_div && cnt == half_m1);
   end

   assign apply_ack = at_boundary && req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= RESET_RATE;
         cnt    <= '0;
         q_div  <= 1'b0;
      end else if (apply_ack) begin
         active <= req_rate;
         cnt    <= '0;
         q_div  <= 1'b0;
      end else if (mode_off || mode_pass) begin
         cnt    <= '0;
         q_div  <= 1'b0;
      end else if (cnt == half_m1) begin
         cnt    <= '0;
         q_div  <= ~q_div;
      end else begin
         cnt    <= cnt + 1'b1;
      end
   end

   // pass-through gate changes only while the reference is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) g_pass <= 1'b0;
      else        g_pass <= mode_pass;
   end

   assign clk_out = (clk & g_pass) | q_div;

   a_r7_switch_in_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active) |-> !$past(q_div));

   a_r7_switch_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active) |-> $past(req_valid));

   a_r2_off_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_off && $past(mode_off)) |-> !q_div);

   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_off && !mode_pass) |-> (cnt <= half_m1));

endmodule

// File: rtl/clko_gen.sv
module clko_gen
   import clko_pkg::*;
#(
   parameter int unsigned RESET_RATE  = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk_ref,
   input  logic                rst_n,
   input  logic                rate_we,
   input  logic [RATE_W-1:0]   rate_wdata,
   input  logic                defer_we,
   input  logic                defer_wdata,
   input  logic                sleep_in,
   output logic                clk_out
);

   localparam rate_t RST_CODE = rate_t'(RESET_RATE);

   logic  req_valid;
   rate_t req_rate;
   logic  apply_ack;

   if (RESET_RATE >= (1 << RATE_W)) begin : g_bad_reset
      $error("clko_gen: RESET_RATE out of range");
   end

   clko_ctrl #(
      .RESET_RATE  (RST_CODE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_ctrl (
      .clk         (clk_ref),
      .rst_n       (rst_n),
      .rate_we     (rate_we),
      .rate_wdata  (rate_wdata),
      .defer_we    (defer_we),
      .defer_wdata (defer_wdata),
      .sleep_in    (sleep_in),
      .apply_ack   (apply_ack),
      .req_valid   (req_valid),
      .req_rate    (req_rate)
   );

   clko_div #(
      .RESET_RATE (RST_CODE),
      .CNT_W      (MAX_LOG2)
   ) u_div (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_rate  (req_rate),
      .apply_ack (apply_ack),
      .clk_out   (clk_out)
   );

endmodule

// File: tb/clko_gen_bench.sv
`timescale 1ns/1ps
module clko_gen_bench;

   logic       clk_ref = 1'b0;
   logic       rst_n = 1'b0;
   logic       rate_we = 1'b0;
   logic [2:0] rate_wdata = 3'd0;
   logic       defer_we = 1'b0;
   logic       defer_wdata = 1'b0;
   logic       sleep_in = 1'b0;
   logic       clk_out;

   int checks = 0;
   int errors = 0;

   // phase tracking, one sample per reference half-cycle
   logic cur = 1'b0;
   int   run = 0;
   int   last_hi = 0;
   int   last_lo = 0;
   int   hi_ends = 0;
   int   lo_ends = 0;
   int   hi_samples = 0;
   bit   mon_on = 0;
   int   mon_a = 0;
   int   mon_b = 0;
   int   mon_err = 0;

   clko_gen u_clko_gen (
      .clk_ref     (clk_ref),
      .rst_n       (rst_n),
      .rate_we     (rate_we),
      .rate_wdata  (rate_wdata),
      .defer_we    (defer_we),
      .defer_wdata (defer_wdata),
      .sleep_in    (sleep_in),
      .clk_out     (clk_out)
   );

   always #2.5 clk_ref = ~clk_ref;

   always begin
      @(clk_ref);
      #1;
      if (clk_out) hi_samples++;
      if (clk_out === cur) begin
         run++;
      end else begin
         if (cur) begin
            last_hi = run;
            hi_ends++;
            if (mon_on && run != mon_a && run != mon_b) mon_err++;
         end else begin
            last_lo = run;
            lo_ends++;
            if (mon_on && run < ((mon_a < mon_b) ? mon_a : mon_b)) mon_err++;
         end
         cur = clk_out;
         run = 1;
      end
   end

   // expected period in reference cycles (= half-samples per phase)
   function automatic int exp_div(input int r);
      if (r >= 1 && r <= 5) return 16 >> (r - 1);
      if (r == 6) return 64;
      if (r == 7) return 256;
      return 0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic write_rate(input int v);
      @(negedge clk_ref);
      rate_we = 1'b1;
      rate_wdata = 3'(v);
      @(negedge clk_ref);
      rate_we = 1'b0;
   endtask

   task automatic write_defer(input bit v);
      @(negedge clk_ref);
      defer_we = 1'b1;
      defer_wdata = v;
      @(negedge clk_ref);
      defer_we = 1'b0;
   endtask

   task automatic sleep_pulse();
      @(negedge clk_ref);
      sleep_in = 1'b1;
      repeat (40) @(negedge clk_ref);
      sleep_in = 1'b0;
   endtask

   task automatic measure(input int r, input string req);
      int h0;
      int l0;
      int e;
      e = exp_div(r);
      h0 = hi_ends;
      wait (hi_ends >= h0 + 3);
      check(last_hi == e, req, last_hi, e);
      l0 = lo_ends;
      wait (lo_ends > l0);
      check(last_lo == e, req, last_lo, e);
   endtask

   task automatic switch_to(input int old_r, input int new_r, input string req);
      mon_err = 0;
      mon_a = exp_div(old_r);
      mon_b = exp_div(new_r);
      mon_on = 1;
      write_rate(new_r);
      measure(new_r, req);
      mon_on = 0;
      check(mon_err == 0, "R7 runt-free switch", mon_err, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk_ref);
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int seq [9] = '{5, 7, 4, 6, 3, 2, 5, 1, 7};
      int prev;
      repeat (5) @(negedge clk_ref);
      check(clk_out == 1'b0, "R1 output low in reset", int'(clk_out), 0);
      rst_n = 1'b1;
      // R1: reset rate is divide by 16
      measure(1, "R1 reset rate");

      // R3 R4 R5 R8: immediate sweep, non-monotonic order
      prev = 1;
      foreach (seq[i]) begin
         switch_to(prev, seq[i], (seq[i] >= 6) ? "R4 R5 R8 rate" : "R3 R5 R8 rate");
         prev = seq[i];
      end

      // R2: code 0 holds the pin low
      mon_a = exp_div(prev); mon_b = exp_div(prev); mon_err = 0; mon_on = 1;
      write_rate(0);
      repeat (700) @(posedge clk_ref);
      mon_on = 0;
      check(mon_err == 0, "R7 switch to off", mon_err, 0);
      hi_samples = 0;
      repeat (1000) @(posedge clk_ref);
      check(hi_samples == 0, "R2 off output low", hi_samples, 0);
      write_rate(3);
      measure(3, "R3 restart from off");

      // R6: deferred writes wait for wake-up, last one wins
      write_defer(1'b1);
      write_rate(6);
      repeat (600) @(posedge clk_ref);
      measure(3, "R6 deferred held");
      write_rate(7);
      write_rate(4);
      @(negedge clk_ref);
      sleep_in = 1'b1;
      repeat (200) @(posedge clk_ref);
      measure(3, "R6 sleep entry no effect");
      @(negedge clk_ref);
      sleep_in = 1'b0;
      measure(4, "R6 last deferred write applied");

      // R9: wake with nothing waiting
      sleep_pulse();
      repeat (50) @(posedge clk_ref);
      measure(4, "R9 idle wake");

      // R9: immediate write cancels waiting code
      write_rate(7);
      write_defer(1'b0);
      write_rate(2);
      measure(2, "R9 immediate overrides deferred");
      sleep_pulse();
      repeat (50) @(posedge clk_ref);
      measure(2, "R9 cancelled code not applied");

      // R5: defer bit 0 again, direct switch to pass-through
      switch_to(2, 5, "R3 R5 pass-through");
      switch_to(5, 6, "R4 R5 from pass-through");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule